// File: doc/BRIEF.md
# Pin Change Notification Controller

This block watches a bank of digital input pins and raises one interrupt request when an enabled pin changes. Each pin passes through a two-flop synchronizer. The block then applies one of two detection styles, chosen by a bit in its control register.

In mismatch style, each pin's synchronized value is compared against a reference. The reference is captured whenever software reads the port data register. Any difference on an enabled pin shows up in a read-only status register. The difference stays visible until the next port read takes a new reference.

In edge style, rising and falling transitions are enabled separately for each pin. Each detected transition sets a sticky flag bit. Software clears a flag by writing zero to that bit.

A global enable bit gates all detection. While the block is disabled, the reference follows the pins, so turning the block on does not report a stale difference.

Software reaches the block through a simple register bus with separate read and write strobes. The interrupt request is a level signal, gated by an external interrupt-enable input.

Top module: `pcn_ctrl`

## Requirements
- R1: After reset, the control, both enable registers and the flag register read as zero, the status register reads zero and `irq_o` is low.
- R2: While the global enable (control bit 15) is 0, no status bit and no flag bit becomes set, whatever the pins do. After the block is enabled, pins that were already high before enabling give no status.
- R3: In mismatch style (control bit 11 = 0), the status register (offset 3) reads (synchronized pins XOR reference) AND the first enable register (offset 1). Pins whose enable bit is 0 read 0.
- R4: A read of the port register (offset 5) returns the synchronized pin values. The same read loads them as the new reference, so the status then reads 0 until a pin changes again.
- R5: In edge style (control bit 11 = 1), a 0-to-1 transition on a pin whose bit is set in the first enable register sets that pin's bit in the flag register (offset 4).
- R6: In edge style, a 1-to-0 transition on a pin whose bit is set in the second enable register (offset 2) sets that pin's flag bit. Transitions that are not enabled set nothing.
- R7: Flag bits are sticky. A write to the flag register clears the bits written as 0 and leaves the bits written as 1 unchanged. A flag bit falls only through such a write.
- R8: When a flag-clearing write and a new enabled edge on the same pin land in the same cycle, the flag bit stays set.
- R9: `irq_o` is `irq_en_i` AND the OR of all status bits in mismatch style, or AND the OR of all flag bits in edge style. `irq_o` is low whenever `irq_en_i` is low.
- R10: A pin change becomes visible in status two clock edges after it is applied, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Asynchronous pin inputs |
| bus_addr_i | input | 3 | Register offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (needed for the port-read side effect) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the current offset |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request level |

## Verification
The cycle that matters most is the one in which a software write of 0 to a flag and a freshly detected edge on the same pin take effect at the same clock edge. The bench provokes it by first letting the pin settle at a non-triggering level. It then applies an enabled rising transition and counts the two synchronizer edges, so that the clearing write completes at exactly the edge where the flag would be set. The flag must read 1 afterwards. A neighbouring flag with no event in that cycle must read 0, which shows that the write itself took effect.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

    localparam int DW       = 16;
    localparam int AW       = 3;
    localparam int BIT_ON   = 15;
    localparam int BIT_EDGE = 11;

    typedef enum logic [AW-1:0] {
        OFS_CTRL = 3'd0,
        OFS_ENA  = 3'd1,
        OFS_ENB  = 3'd2,
        OFS_STAT = 3'd3,
        OFS_FLAG = 3'd4,
        OFS_PORT = 3'd5
    } ofs_e;

    typedef struct packed {
        logic on;
        logic edge_sel;
    } ctrl_t;

    function automatic logic [DW-1:0] pack_ctrl(ctrl_t c);
        logic [DW-1:0] v;
        v = '0;
        v[BIT_ON]   = c.on;
        v[BIT_EDGE] = c.edge_sel;
        return v;
    endfunction

endpackage

// File: rtl/pcn_sync.sv
module pcn_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_i[g];
                s2 <= s1;
            end
        end
        assign q_o[g] = s2;
    end
endmodule

// File: rtl/pcn_detect.sv
module pcn_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic         on_i,
    input  logic         edge_i,
    input  logic         ref_load_i,
    input  logic [W-1:0] en_a_i,
    input  logic [W-1:0] en_b_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] ev_o
);
    logic [W-1:0] ref_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pin_i;
            if (!on_i || ref_load_i) ref_q <= pin_i;
        end
    end

    always_comb begin
        status_o = '0;
        ev_o     = '0;
        if (on_i && !edge_i)
            status_o = (pin_i ^ ref_q) & en_a_i;
        if (on_i && edge_i)
            ev_o = (pin_i & ~prev_q & en_a_i) | (~pin_i & prev_q & en_b_i);
    end
endmodule

// File: rtl/pcn_flags.sv
module pcn_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] keep;

    always_comb keep = clr_wr_i ? clr_data_i : '1;

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= (flags_o & keep) | ev_i;
    end
endmodule

// File: rtl/pcn_ctrl.sv
module pcn_ctrl
    import pcn_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [DW-1:0]    bus_rdata_o,
    input  logic             irq_en_i,
    output logic             irq_o
);
    ctrl_t            ctrl_q;
    logic [NPINS-1:0] en_a_q, en_b_q;
    logic [NPINS-1:0] pin_s, status, edge_ev, flags_q;
    logic             flag_wr, port_rd;
    ofs_e             ofs;

    assign ofs     = ofs_e'(bus_addr_i);
    assign flag_wr = bus_wr_i && ofs == OFS_FLAG;
    assign port_rd = bus_rd_i && ofs == OFS_PORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_a_q <= '0;
            en_b_q <= '0;
        end else if (bus_wr_i) begin
            case (ofs)
                OFS_CTRL: begin
                    ctrl_q.on       <= bus_wdata_i[BIT_ON];
                    ctrl_q.edge_sel <= bus_wdata_i[BIT_EDGE];
                end
                OFS_ENA: en_a_q <= bus_wdata_i[NPINS-1:0];
                OFS_ENB: en_b_q <= bus_wdata_i[NPINS-1:0];
                default: ;
            endcase
        end
    end

    pcn_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .d_i(pins_i), .q_o(pin_s)
    );

    pcn_detect #(.W(NPINS)) u_detect (
        .clk(clk), .rst(rst), .pin_i(pin_s),
        .on_i(ctrl_q.on), .edge_i(ctrl_q.edge_sel), .ref_load_i(port_rd),
        .en_a_i(en_a_q), .en_b_i(en_b_q),
        .status_o(status), .ev_o(edge_ev)
    );

    pcn_flags #(.W(NPINS)) u_flags (
        .clk(clk), .rst(rst), .ev_i(edge_ev),
        .clr_wr_i(flag_wr), .clr_data_i(bus_wdata_i[NPINS-1:0]),
        .flags_o(flags_q)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (ofs)
            OFS_CTRL: bus_rdata_o = pack_ctrl(ctrl_q);
            OFS_ENA:  bus_rdata_o[NPINS-1:0] = en_a_q;
            OFS_ENB:  bus_rdata_o[NPINS-1:0] = en_b_q;
            OFS_STAT: bus_rdata_o[NPINS-1:0] = status;
            OFS_FLAG: bus_rdata_o[NPINS-1:0] = flags_q;
            OFS_PORT: bus_rdata_o[NPINS-1:0] = pin_s;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o = irq_en_i && (ctrl_q.edge_sel ? |flags_q : |status);

endmodule

// File: rtl/pcn_ctrl_chk.sv
module pcn_ctrl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         irq_o,
    input logic         irq_en_i,
    input logic         on,
    input logic         edge_sel,
    input logic         flag_wr,
    input logic [W-1:0] ev,
    input logic [W-1:0] flags
);
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o);

    p_off_no_flag_r2: assert property (@(posedge clk) disable iff (rst)
        !on |=> ((flags & ~$past(flags)) == '0));

    p_mismatch_no_flag_r3: assert property (@(posedge clk) disable iff (rst)
        !edge_sel |=> ((flags & ~$past(flags)) == '0));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((~flags & $past(flags)) == '0));

    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));
endmodule

bind pcn_ctrl pcn_ctrl_chk #(.W(NPINS)) u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .irq_en_i(irq_en_i),
    .on(ctrl_q.on), .edge_sel(ctrl_q.edge_sel), .flag_wr(flag_wr),
    .ev(edge_ev), .flags(flags_q)
);

// File: tb/pcn_ctrl_tb_top.sv
module pcn_ctrl_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [N-1:0] pins;
    logic [2:0]  addr;
    logic        wr, rd, irq_en;
    logic [15:0] wdata, rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pcn_ctrl #(.NPINS(N)) dut_i (
        .clk(clk), .rst(rst), .pins_i(pins), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_en_i(irq_en), .irq_o(irq)
    );

    // {pins, enable, expected status}
    localparam logic [23:0] VEC [6] = '{
        24'h01_FF_01, 24'hF0_0F_00, 24'hA5_FF_A5,
        24'h3C_30_30, 24'h80_80_80, 24'hFF_00_00
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic bus_rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1; pins = '0; addr = '0; wr = 0; rd = 0; wdata = '0; irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        bus_rd(3'd0, d); chk("R1 ctrl", d, 16'h0);
        bus_rd(3'd1, d); chk("R1 ena", d, 16'h0);
        bus_rd(3'd4, d); chk("R1 flags", d, 16'h0);
        bus_rd(3'd3, d); chk("R1 status", d, 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);

        // R2 disabled: edge style selected but global enable off
        bus_wr(3'd1, 16'h00FF);
        bus_wr(3'd0, 16'h0800);
        pins = 8'hFF; settle();
        bus_rd(3'd4, d); chk("R2 no flags while off", d, 16'h0);
        bus_wr(3'd0, 16'h8000);
        settle();
        bus_rd(3'd3, d); chk("R2 no status after enable", d, 16'h0);

        // R3 mismatch table
        pins = 8'h00; settle();
        bus_rd(3'd5, d);
        foreach (VEC[i]) begin
            bus_wr(3'd1, {8'h00, VEC[i][15:8]});
            pins = VEC[i][23:16]; settle();
            bus_rd(3'd3, d); chk("R3 status", d, {8'h00, VEC[i][7:0]});
            chk("R9 irq mismatch", 16'(irq), 16'(|VEC[i][7:0]));
            pins = 8'h00; settle();
            bus_rd(3'd5, d);
        end

        // R4 port read
        bus_wr(3'd1, 16'h00FF);
        pins = 8'h5A; settle();
        bus_rd(3'd5, d); chk("R4 port value", d, 16'h005A);
        bus_rd(3'd3, d); chk("R4 status cleared", d, 16'h0);

        // R10 synchronizer latency
        @(negedge clk) pins = 8'h5B;
        bus_rd(3'd3, d); chk("R10 after one edge", d, 16'h0);
        bus_rd(3'd3, d); chk("R10 after two edges", d, 16'h0001);
        irq_en = 1'b0; #1;
        chk("R9 irq gated", 16'(irq), 16'h0);
        irq_en = 1'b1;

        // Edge style
        bus_wr(3'd1, 16'h000F);
        bus_wr(3'd2, 16'h00F0);
        bus_wr(3'd0, 16'h8800);
        bus_wr(3'd4, 16'h0000);
        pins = 8'h00; settle();
        bus_rd(3'd4, d); chk("R6 falling flags", d, 16'h0050);
        pins = 8'h0F; settle();
        bus_rd(3'd4, d); chk("R5 rising flags", d, 16'h005F);
        #1 chk("R9 irq edge", 16'(irq), 16'h1);

        // R7 write semantics
        bus_wr(3'd4, 16'h00FF);
        bus_rd(3'd4, d); chk("R7 write ones no effect", d, 16'h005F);
        bus_wr(3'd4, 16'h00F0);
        bus_rd(3'd4, d); chk("R7 write zeros clear", d, 16'h0050);
        pins = 8'h0E; settle();
        pins = 8'h0F; settle();
        bus_rd(3'd4, d); chk("R7 rearmed after clear", d, 16'h0051);

        // R8 clear collides with new edge on pin 2
        pins = 8'h0B; settle();
        @(negedge clk) pins = 8'h0F;
        @(posedge clk); @(posedge clk);
        bus_wr(3'd4, 16'h0000);
        bus_rd(3'd4, d); chk("R8 edge wins over clear", d, 16'h0004);

        bus_wr(3'd4, 16'h0000);
        bus_rd(3'd4, d); chk("R7 all cleared", d, 16'h0);
        #1 chk("R9 irq low with no flags", 16'(irq), 16'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule